// File: doc/BRIEF.md
# SPI EEPROM Word Controller

This controller moves 16-bit host words to and from a byte-addressed serial EEPROM on a mode-0 SPI link. The host gives a start pulse with a direction, a starting word offset, a word count and, for writes, one data word at a time. The controller checks that the request fits inside the device. It waits for the device to report that it is not busy, and then runs the transfer on the serial pins. Done pulses at the end, and err tells whether the request failed.

Each word is mapped onto two device bytes: word k lives at byte addresses 2k and 2k+1, with the low-order byte of the host word at the even address. The device may take 8 address bits. In that case the ninth byte-address bit travels inside the command byte. Writes are cut into bursts that never cross a device page. Every burst starts with its own busy poll and its own write-enable frame.

Top module: `spi_eeprom_ctl`

## Requirements
- R1: A request is rejected when offset >= DEV_WORDS, when count is 0, or when offset + count > DEV_WORDS. Done and err are then high in the cycle after start, and cs_n never goes low.
- R2: The link runs in SPI mode 0. sclk is low whenever cs_n is high, and mosi changes only while sclk is low. Every field goes out most-significant bit first, and miso is sampled while sclk is high.
- R3: Every burst starts with a status poll: command 0x05, then 8 status bits clocked in. The poll repeats while status bit 0 (busy) is 1, with a POLL_GAP-cycle wait and a standby between tries. After RETRY_MAX busy answers the request ends with err=1, and no read or write command is sent.
- R4: The address sent after a read or write command is the current word offset times 2. With ADDR_BITS=8 it is 8 bits wide; with ADDR_BITS=16 it is 16 bits wide.
- R5: With ADDR_BITS=8, when bit 8 of the byte address is 1, the value 0x08 is ORed into the command byte.
- R6: A read sends command 0x03 and the address once. It then clocks in 16 bits per word with no gap in the frame. Each word is returned on rdata with word_tick high for one cycle: the first byte received becomes bits 7:0, and the second byte becomes bits 15:8.
- R7: A write shifts each wdata word out low byte first, then high byte. word_tick pulses when wdata has been taken, and the next word must be presented before the following word starts.
- R8: Each write burst is preceded by a command-0x06 frame of its own, closed by a standby. The write command byte is 0x02 (with the R5 bit).
- R9: After a written word at offset o, if (o+1)*2 is a multiple of PAGE_BYTES, the burst ends with a standby. If words remain, a new R3 poll and R8 enable follow, and the address is sent afresh.
- R10: After the last write word, the controller waits at least WR_WAIT cycles before raising cs_n and pulsing done.
- R11: done is a single-cycle pulse. While the controller is idle, cs_n is high.
- R12: A standby holds cs_n high for exactly HALF_CLKS cycles and then low for HALF_CLKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a request (sampled when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| offset | input | OW | First word offset |
| count | input | OW | Number of words |
| wdata | input | 16 | Write word currently offered |
| rdata | output | 16 | Last word read |
| word_tick | output | 1 | Read word valid / write word taken |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request rejected or device stayed busy |
| cs_n | output | 1 | Device select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
The bench attacks the page edges with writes that stop just before a page end, cross it, or land exactly on it. A controller that ignores pages makes the device wrap inside the page, and the data lands on the wrong bytes. Writes and reads on both sides of word 128 catch a lost ninth address bit, which would alias the upper half onto the lower. A device left busy on purpose checks that the poll gives up after exactly RETRY_MAX tries without sending a command. Rejected requests must finish at once without touching cs_n. A missing settle wait shows up as done arriving too soon after the last clock. A missing byte swap shows up as both bytes exchanged in every word.

// File: rtl/spi_eeprom_ctl.sv
module spi_eeprom_ctl #(
  parameter int DEV_WORDS  = 256,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int HALF_CLKS  = 2,
  parameter int RETRY_MAX  = 8,
  parameter int POLL_GAP   = 500,
  parameter int WR_WAIT    = 1000000,
  localparam int OW = $clog2(DEV_WORDS) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [OW-1:0] offset,
  input  logic [OW-1:0] count,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          word_tick,
  output logic          done,
  output logic          err,
  output logic          cs_n,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int PGW = $clog2(PAGE_BYTES);
  localparam int HDR = (ADDR_BITS == 8) ? 16 : 24;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_POLLCHK, S_GAP, S_STBY_HI, S_STBY_LO, S_WREN, S_WREN2,
    S_CMD, S_WORD, S_WORDCHK, S_WAIT, S_STOP, S_DONE, S_XFER
  } st_t;

  st_t st, ret;
  logic          op_wr;
  logic [OW-1:0] cur, left;
  logic [23:0]   sr;
  logic [15:0]   rx;
  logic [4:0]    nb;
  logic [31:0]   tmr;
  logic [15:0]   tries;
  logic          idle, bad, half_end, pg_end;
  logic [16:0]   bext, nbext;
  logic [7:0]    op;

  assign idle     = (st == S_IDLE);
  assign bad      = (int'(offset) >= DEV_WORDS) || (count == '0) ||
                    (int'(offset) + int'(count) > DEV_WORDS);
  assign half_end = (tmr == 32'(HALF_CLKS - 1));
  assign bext     = 17'(cur) << 1;
  assign nbext    = (17'(cur) + 17'd1) << 1;
  assign pg_end   = (nbext[PGW-1:0] == '0);
  assign op       = (op_wr ? 8'h02 : 8'h03) |
                    (((ADDR_BITS == 8) && bext[8]) ? 8'h08 : 8'h00);
  assign mosi     = (st == S_XFER) && sr[23];
  assign done     = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ret <= S_IDLE;  op_wr <= 1'b0;
      cur <= '0;  left <= '0;  sr <= '0;  rx <= '0;  nb <= '0;
      tmr <= '0;  tries <= '0;  rdata <= '0;  word_tick <= 1'b0;
      err <= 1'b0;  cs_n <= 1'b1;  sclk <= 1'b0;
    end else begin
      word_tick <= 1'b0;
      if (idle) begin
        if (start) begin
          op_wr <= wr;  cur <= offset;  left <= count;  tries <= '0;
          if (bad) begin
            err <= 1'b1;
            st  <= S_DONE;
          end else begin
            err  <= 1'b0;
            cs_n <= 1'b0;
            sclk <= 1'b0;
            st   <= S_POLL;
          end
        end
      end else begin
        case (st)
          S_POLL: begin
            sr <= {8'h05, 16'h0000};  nb <= 5'd16;
            ret <= S_POLLCHK;  st <= S_XFER;
          end
          S_POLLCHK: begin
            if (!rx[0]) begin
              cs_n <= 1'b1;
              ret  <= op_wr ? S_WREN : S_CMD;
              st   <= S_STBY_HI;
            end else if (tries == 16'(RETRY_MAX - 1)) begin
              err <= 1'b1;
              st  <= S_STOP;
            end else begin
              tries <= tries + 16'd1;
              st    <= S_GAP;
            end
          end
          S_GAP: begin
            if (tmr == 32'(POLL_GAP - 1)) begin
              tmr <= '0;  cs_n <= 1'b1;  ret <= S_POLL;  st <= S_STBY_HI;
            end else tmr <= tmr + 32'd1;
          end
          S_STBY_HI: begin
            if (half_end) begin
              tmr <= '0;  cs_n <= 1'b0;  st <= S_STBY_LO;
            end else tmr <= tmr + 32'd1;
          end
          S_STBY_LO: begin
            if (half_end) begin
              tmr <= '0;  st <= ret;
            end else tmr <= tmr + 32'd1;
          end
          S_WREN: begin
            sr <= {8'h06, 16'h0000};  nb <= 5'd8;
            ret <= S_WREN2;  st <= S_XFER;
          end
          S_WREN2: begin
            cs_n <= 1'b1;  ret <= S_CMD;  st <= S_STBY_HI;
          end
          S_CMD: begin
            if (ADDR_BITS == 8) sr <= {op, bext[7:0], 8'h00};
            else                sr <= {op, bext[15:0]};
            nb  <= 5'(HDR);
            ret <= S_WORD;  st <= S_XFER;
          end
          S_WORD: begin
            sr        <= op_wr ? {wdata[7:0], wdata[15:8], 8'h00} : 24'h0;
            word_tick <= op_wr;
            nb  <= 5'd16;
            ret <= S_WORDCHK;  st <= S_XFER;
          end
          S_WORDCHK: begin
            if (!op_wr) begin
              rdata     <= {rx[7:0], rx[15:8]};
              word_tick <= 1'b1;
            end
            cur  <= cur + 1'b1;
            left <= left - 1'b1;
            if (op_wr && pg_end) begin
              cs_n  <= 1'b1;
              tries <= '0;
              ret   <= (left == 1) ? S_WAIT : S_POLL;
              st    <= S_STBY_HI;
            end else if (left == 1) st <= op_wr ? S_WAIT : S_STOP;
            else st <= S_WORD;
          end
          S_WAIT: begin
            if (tmr == 32'(WR_WAIT - 1)) begin
              tmr <= '0;  st <= S_STOP;
            end else tmr <= tmr + 32'd1;
          end
          S_STOP: begin
            cs_n <= 1'b1;  sclk <= 1'b0;  st <= S_DONE;
          end
          S_DONE: st <= S_IDLE;
          S_XFER: begin
            if (half_end) begin
              tmr <= '0;
              if (!sclk) sclk <= 1'b1;
              else begin
                sclk <= 1'b0;
                rx   <= {rx[14:0], miso};
                sr   <= {sr[22:0], 1'b0};
                nb   <= nb - 5'd1;
                if (nb == 5'd1) st <= ret;
              end
            end else tmr <= tmr + 32'd1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_ctl_chk.sv
module spi_eeprom_ctl_chk #(
  parameter int DEV_WORDS = 256,
  localparam int OW = $clog2(DEV_WORDS) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          idle,
  input logic          done,
  input logic          err,
  input logic          cs_n,
  input logic          sclk,
  input logic          mosi,
  input logic          word_tick,
  input logic [OW-1:0] offset,
  input logic [OW-1:0] count
);
  logic req_out_of_range;
  assign req_out_of_range = (int'(offset) >= DEV_WORDS) || (count == '0) ||
                            (int'(offset) + int'(count) > DEV_WORDS);

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && req_out_of_range) |=> (done && err && cs_n));

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  p_tick_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick |-> !cs_n);

  p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> cs_n);
endmodule

bind spi_eeprom_ctl spi_eeprom_ctl_chk #(.DEV_WORDS(DEV_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done),
  .err(err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .word_tick(word_tick),
  .offset(offset), .count(count)
);

// File: tb/spi_eeprom_ctl_test.sv
module spi_eeprom_ctl_test;
  localparam int DW = 256, OW = 9, HALF = 2, RMAX = 8, WRW = 300, PGB = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, wr = 1'b0;
  logic [OW-1:0] offset = '0, count = '0;
  logic [15:0] wdata = '0, rdata;
  logic word_tick, done, err, cs_n, sclk, mosi;
  logic miso = 1'b0;

  spi_eeprom_ctl #(.DEV_WORDS(DW), .ADDR_BITS(8), .PAGE_BYTES(PGB), .HALF_CLKS(HALF),
                   .RETRY_MAX(RMAX), .POLL_GAP(10), .WR_WAIT(WRW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .offset(offset), .count(count),
    .wdata(wdata), .rdata(rdata), .word_tick(word_tick), .done(done), .err(err),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device responder, evaluated between clock edges
  logic [7:0] mem [0:511];
  logic [7:0] cmd, sh;
  logic [8:0] raddr;
  int bitn, wren_cnt, wrcmd_cnt, rdcmd_cnt, poll_cnt, busy_left;
  bit wel, wrote, stuck = 0;
  logic p_cs = 1'b1, p_sk = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) & 255);
      bitn = 0; wren_cnt = 0; wrcmd_cnt = 0; rdcmd_cnt = 0; poll_cnt = 0;
      busy_left = 0; wel = 0; wrote = 0; cmd = 0; sh = 0; raddr = 0;
    end else begin
      if (p_cs && !cs_n) begin bitn = 0; cmd = 0; end
      if (!cs_n && sclk && !p_sk) begin
        sh = {sh[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          cmd = sh;
          if ((cmd & 8'hF7) == 8'h03) rdcmd_cnt++;
          if ((cmd & 8'hF7) == 8'h02) wrcmd_cnt++;
        end else if (bitn == 16) begin
          if (cmd == 8'h05) begin poll_cnt++; if (busy_left > 0) busy_left--; end
          else raddr = {cmd[3], sh};
        end else if (bitn > 16 && bitn % 8 == 0 && (cmd & 8'hF7) == 8'h02 && wel) begin
          mem[raddr] = sh; wrote = 1;
          raddr = {raddr[8:5], raddr[4:0] + 5'd1};
        end
      end
      if (!cs_n && !sclk && p_sk) begin
        if (cmd == 8'h05 && bitn >= 8)
          miso = (bitn == 15) ? (stuck || busy_left > 0) : 1'b0;
        else if ((cmd & 8'hF7) == 8'h03 && bitn >= 16)
          miso = mem[9'(int'(raddr) + (bitn - 16) / 8)][7 - ((bitn - 16) % 8)];
        else miso = 1'b0;
      end
      if (!p_cs && cs_n) begin
        if (cmd == 8'h06 && bitn == 8) begin wel = 1; wren_cnt++; end
        if (wrote) begin wel = 0; wrote = 0; busy_left = 2; end
      end
      p_cs = cs_n; p_sk = sclk;
    end
  end

  // pin monitors
  int since_sk = 0, hi_w = 100, pulses = 0, pw_bad = 0, mosi_bad = 0, low_cyc = 0;
  logic pm = 1'b0;
  always @(negedge clk) begin
    if (sclk) since_sk = 0; else since_sk++;
    if (sclk && mosi !== pm) mosi_bad++;
    pm = mosi;
    if (cs_n) hi_w++;
    else begin
      low_cyc++;
      if (hi_w > 0 && hi_w < 10) begin pulses++; if (hi_w != HALF) pw_bad++; end
      hi_w = 0;
    end
  end

  function automatic logic [15:0] wfun(input int k);
    return {8'(k + 8'h40), 8'(~k)};
  endfunction

  int rd_delta, poll_delta;
  task automatic run_op(input bit w, input int off, input int cnt, input bit exp_err);
    int idx = 0, cyc = 0, wr0, wren0, rd0, pl0, low0, bursts;
    wr0 = wrcmd_cnt; wren0 = wren_cnt; rd0 = rdcmd_cnt; pl0 = poll_cnt; low0 = low_cyc;
    @(negedge clk);
    wr = w; offset = OW'(off); count = OW'(cnt); wdata = wfun(off); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 60000) begin
      if (word_tick) begin
        if (!w) chk(rdata == {mem[2*(off+idx)+1], mem[2*(off+idx)]}, "R6 R4",
                    "read word", rdata, {mem[2*(off+idx)+1], mem[2*(off+idx)]});
        idx++;
        if (w) wdata = wfun(off + idx);
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 60000, "R11", "done seen", cyc, 0);
    chk(err == exp_err, exp_err ? "R1" : "R11", "err flag", err, exp_err);
    rd_delta = rdcmd_cnt - rd0; poll_delta = poll_cnt - pl0;
    if (exp_err && cnt > 0 && off + cnt <= DW && off < DW) begin
      // device-timeout case checked by caller
    end else if (exp_err) begin
      chk(cyc == 0, "R1", "reject latency", cyc, 0);
      chk(low_cyc == low0, "R1", "cs_n stayed high", low_cyc - low0, 0);
    end else begin
      chk(idx == cnt, w ? "R7" : "R6", "word ticks", idx, cnt);
      if (w) begin
        bursts = 1;
        for (int i = 0; i < cnt - 1; i++) if (((off + i + 1) * 2) % PGB == 0) bursts++;
        chk(wren_cnt - wren0 == bursts, "R8", "enable frames", wren_cnt - wren0, bursts);
        chk(wrcmd_cnt - wr0 == bursts, "R9", "write bursts", wrcmd_cnt - wr0, bursts);
        chk(since_sk >= WRW, "R10", "settle cycles", since_sk, WRW);
        for (int i = 0; i < cnt; i++) begin
          chk({mem[2*(off+i)+1], mem[2*(off+i)]} == wfun(off + i),
              (off + i >= 128) ? "R5 R7" : "R7", "stored word",
              {mem[2*(off+i)+1], mem[2*(off+i)]}, wfun(off + i));
        end
      end else begin
        chk(rd_delta == 1, "R6", "read commands", rd_delta, 1);
      end
    end
    @(negedge clk);
    chk(!done, "R11", "done width", done, 0);
    repeat (20) @(negedge clk);
  endtask

  // {wr, offset, count, err}
  localparam bit [19:0] VEC [0:11] = '{
    {1'b0, 9'd0,   9'd4,   1'b0}, {1'b0, 9'd250, 9'd6, 1'b0},
    {1'b0, 9'd127, 9'd3,   1'b0}, {1'b0, 9'd200, 9'd2, 1'b0},
    {1'b1, 9'd14,  9'd4,   1'b0}, {1'b1, 9'd126, 9'd4, 1'b0},
    {1'b1, 9'd255, 9'd1,   1'b0}, {1'b1, 9'd60,  9'd3, 1'b0},
    {1'b0, 9'd256, 9'd1,   1'b1}, {1'b0, 9'd10,  9'd0, 1'b1},
    {1'b1, 9'd250, 9'd7,   1'b1}, {1'b0, 9'd0,   9'd256, 1'b0}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R2", "reset pins", {cs_n, sclk}, 2'b10);
    chk(done == 1'b0 && word_tick == 1'b0, "R11", "reset outputs", {done, word_tick}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int v = 0; v < 12; v++)
      run_op(VEC[v][19], int'(VEC[v][18:10]), int'(VEC[v][9:1]), VEC[v][0]);
    stuck = 1;
    run_op(1'b0, 5, 1, 1'b1);
    chk(poll_delta == RMAX, "R3", "polls before give-up", poll_delta, RMAX);
    chk(rd_delta == 0, "R3", "no command after timeout", rd_delta, 0);
    stuck = 0;
    run_op(1'b0, 14, 4, 1'b0);
    chk(pulses > 0 && pw_bad == 0, "R12", "standby widths", pw_bad, 0);
    chk(mosi_bad == 0, "R2", "mosi moved with sclk high", mosi_bad, 0);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog: actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end
endmodule